// File: doc/BRIEF.md
# Parallel Neural Surface-Code Decoder (distance 3)

This block decodes one syndrome of a distance-3 surface code and returns a Pauli correction for each of its nine data qubits. Two small fixed-point perceptrons, each with one ReLU hidden layer, are started on the same latched syndrome in the same cycle. The first scores the four Pauli states of every data qubit. The second scores four logical classes. When both have finished, the per-qubit guess is merged with the logical operator the classifier picked, and a one-cycle done pulse carries the result out. Decode latency is set by the wider classifier path and does not add the two paths together.

Weights and biases sit in registers inside each network and are written one byte per cycle through a small write port while the block is idle. The first layer adds the selected weights without multiplying, because syndrome bits are 0 or 1. The output layer multiplies 7-bit hidden activations by signed 8-bit weights into saturating 16-bit accumulators.

Top module: `surface_nn_decoder`

## Requirements
- R1: After reset `done` is 0, `correction` is 0, `logical` is 0 (class I), and every weight and bias of both networks is 0.
- R2: Hidden neuron j equals its bias plus the sum of the first-layer weights whose syndrome bit is 1, clamped to 0..127. In the first layer, write address j*9+i holds the weight for syndrome bit i (i=0..7), and address j*9+8 holds the bias.
- R3: Output neuron o starts at its bias and adds hidden[j]*weight in order j=0,1,...,H-1. After each addition it saturates to the signed 16-bit range. In the second layer, address o*(H+1)+j holds the weight for hidden j, and address o*(H+1)+H holds the bias. H is 15 for the predictor and 60 for the classifier.
- R4: Predictor outputs 4q+0..4q+3 score qubit q as none, X, Y or Z. The largest score wins, and a tie goes to the lower index. A state is coded as (x,z) with I=00, X=10, Z=01, Y=11, and qubit q=row*3+col sits in `correction[2q+1:2q]`.
- R5: Classifier outputs 0..3 score logical classes I, X, Y and Z. The largest wins, and a tie goes to the lower index. `logical` uses the same (x,z) code as R4.
- R6: Logical X toggles the x bit on qubits 0, 1 and 2 (first row). Logical Z toggles the z bit on qubits 0, 3 and 6 (first column). Logical Y does both, and class I leaves the per-qubit guess unchanged.
- R7: Both networks start in the cycle a start is accepted. `done` is high for exactly one cycle, 121 clock edges after the accepting edge (two passes over the 60 classifier hidden neurons plus one). The outputs hold their values until the next done.
- R8: A start that arrives while a decode is running is ignored. Only one done follows, and it carries the first syndrome's result.
- R9: `wr_net` selects the network (0 predictor, 1 classifier) and `wr_layer` selects the layer (0 first, 1 second). A write that arrives while a decode is running is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start a decode of `syndrome` |
| syndrome | input | 8 | One bit per ancilla |
| wr_en | input | 1 | Parameter write strobe |
| wr_net | input | 1 | 0 predictor, 1 classifier |
| wr_layer | input | 1 | 0 first layer, 1 second layer |
| wr_addr | input | 10 | Parameter address within the layer |
| wr_data | input | 8 | Signed weight or bias |
| done | output | 1 | One-cycle result strobe |
| correction | output | 18 | Per-qubit (x,z) correction |
| logical | output | 2 | Chosen logical class, (x,z) coded |

## Verification
All-zero parameters show the tie rule and the cleared reset state. Bias-only classifier settings, with predictor guesses on or off the logical chains, separate the X, Y, Z and I merge paths and show whether a toggle lands on the row or the column. Single hand-placed weights check the write address mapping. Classifier weights large enough to overflow show saturation as opposed to wrap-around. Pseudo-random parameters with sparse, dense and single-bit syndromes compare the whole datapath against an integer model. Starts and writes issued mid-decode show whether the busy window is respected.

// File: rtl/snd_pkg.sv
package snd_pkg;
    localparam int DIST   = 3;
    localparam int NQ     = DIST * DIST;
    localparam int SYN_W  = NQ - 1;
    localparam int P_HID  = 5 * DIST;
    localparam int C_HID  = 20 * DIST;
    localparam int P_OUT  = 4 * NQ;
    localparam int C_OUT  = 4;
    localparam int W_W    = 8;
    localparam int H_W    = 7;
    localparam int ACC_W  = 16;
    localparam int AW     = 10;

    typedef enum logic {ST_IDLE, ST_RUN} dec_state_t;
    typedef enum logic [1:0] {PH_IDLE, PH_HID, PH_OUT} eng_phase_t;

    // (x,z) coded Pauli values
    localparam logic [1:0] PAULI_I = 2'b00;
    localparam logic [1:0] PAULI_X = 2'b10;
    localparam logic [1:0] PAULI_Y = 2'b11;
    localparam logic [1:0] PAULI_Z = 2'b01;

    // Saturate an extended sum back to ACC_W bits
    function automatic logic [ACC_W-1:0] sat_acc(input logic [ACC_W+1:0] v);
        if (v[ACC_W+1:ACC_W-1] == 3'b000 || v[ACC_W+1:ACC_W-1] == 3'b111)
            return v[ACC_W-1:0];
        else if (v[ACC_W+1])
            return {1'b1, {(ACC_W-1){1'b0}}};
        else
            return {1'b0, {(ACC_W-1){1'b1}}};
    endfunction

    // ReLU with upper clamp into H_W unsigned bits
    function automatic logic [H_W-1:0] relu_clamp(input logic [15:0] v);
        if (v[15])
            return '0;
        else if (|v[14:H_W])
            return '1;
        else
            return v[H_W-1:0];
    endfunction

    // Index of the largest of four signed scores; ties keep the lower index
    function automatic logic [1:0] argmax4(input logic [3:0][ACC_W-1:0] v);
        logic [1:0] best;
        best = 2'd0;
        for (int k = 1; k < 4; k++)
            if ($signed(v[k]) > $signed(v[best])) best = 2'(k);
        return best;
    endfunction

    // Score order none, X, Y, Z mapped to (x,z) code
    function automatic logic [1:0] idx2pauli(input logic [1:0] idx);
        case (idx)
            2'd1:    return PAULI_X;
            2'd2:    return PAULI_Y;
            2'd3:    return PAULI_Z;
            default: return PAULI_I;
        endcase
    endfunction
endpackage

// File: rtl/snd_net_engine.sv
module snd_net_engine
    import snd_pkg::*;
#(
    parameter int IN_W  = 8,
    parameter int HID_N = 15,
    parameter int OUT_N = 36
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        go,
    input  logic [IN_W-1:0]             syn,
    input  logic                        wr_en,
    input  logic                        wr_layer,
    input  logic [AW-1:0]               wr_addr,
    input  logic [W_W-1:0]              wr_data,
    output logic                        fin,
    output logic [OUT_N-1:0][ACC_W-1:0] score
);
    localparam int CW     = (HID_N > 1) ? $clog2(HID_N) : 1;
    localparam int L1_ROW = IN_W + 1;
    localparam int L2_ROW = HID_N + 1;

    logic signed [W_W-1:0] w1 [HID_N][IN_W];
    logic signed [W_W-1:0] b1 [HID_N];
    logic signed [W_W-1:0] w2 [OUT_N][HID_N];
    logic signed [W_W-1:0] b2 [OUT_N];
    logic [H_W-1:0]        hact [HID_N];
    logic signed [ACC_W-1:0] acc [OUT_N];
    logic signed [ACC_W-1:0] acc_nx [OUT_N];

    eng_phase_t     phase;
    logic [CW-1:0]  cnt;
    logic           last;
    logic signed [15:0] hsum;

    assign last = (cnt == CW'(HID_N - 1));

    // Parameter storage with addressed writes
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < HID_N; j++) begin
                b1[j] <= '0;
                for (int i = 0; i < IN_W; i++) w1[j][i] <= '0;
            end
            for (int o = 0; o < OUT_N; o++) begin
                b2[o] <= '0;
                for (int j = 0; j < HID_N; j++) w2[o][j] <= '0;
            end
        end else if (wr_en) begin
            if (!wr_layer) begin
                for (int j = 0; j < HID_N; j++) begin
                    for (int i = 0; i < IN_W; i++)
                        if (wr_addr == AW'(j * L1_ROW + i)) w1[j][i] <= $signed(wr_data);
                    if (wr_addr == AW'(j * L1_ROW + IN_W)) b1[j] <= $signed(wr_data);
                end
            end else begin
                for (int o = 0; o < OUT_N; o++) begin
                    for (int j = 0; j < HID_N; j++)
                        if (wr_addr == AW'(o * L2_ROW + j)) w2[o][j] <= $signed(wr_data);
                    if (wr_addr == AW'(o * L2_ROW + HID_N)) b2[o] <= $signed(wr_data);
                end
            end
        end
    end

    // First layer: add the weights of the set syndrome bits
    always_comb begin
        hsum = 16'(b1[cnt]);
        for (int i = 0; i < IN_W; i++)
            if (syn[i]) hsum = hsum + 16'(w1[cnt][i]);
    end

    // Output layer: one hidden neuron folded into every accumulator per cycle
    always_comb begin
        for (int o = 0; o < OUT_N; o++)
            acc_nx[o] = $signed(sat_acc(18'(acc[o]) +
                        18'($signed({1'b0, hact[cnt]})) * 18'(w2[o][cnt])));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            fin   <= 1'b0;
            for (int j = 0; j < HID_N; j++) hact[j] <= '0;
            for (int o = 0; o < OUT_N; o++) acc[o] <= '0;
        end else if (go) begin
            phase <= PH_HID;
            cnt   <= '0;
            fin   <= 1'b0;
            for (int o = 0; o < OUT_N; o++) acc[o] <= ACC_W'(b2[o]);
        end else begin
            case (phase)
                PH_HID: begin
                    hact[cnt] <= relu_clamp(hsum);
                    if (last) begin
                        cnt   <= '0;
                        phase <= PH_OUT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_OUT: begin
                    for (int o = 0; o < OUT_N; o++) acc[o] <= acc_nx[o];
                    if (last) begin
                        phase <= PH_IDLE;
                        fin   <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    for (genvar o = 0; o < OUT_N; o++) begin : g_score
        assign score[o] = acc[o];
    end

    // R3: the neuron counter never leaves the hidden range during a pass
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_IDLE) |-> (cnt <= CW'(HID_N - 1)));
    // R7: a finished engine stays idle until the next go
    a_r7_fin_idle: assert property (@(posedge clk) disable iff (rst)
        (fin && !go) |=> (fin && phase == PH_IDLE));
endmodule

// File: rtl/snd_merge.sv
module snd_merge
    import snd_pkg::*;
#(
    parameter int SIDE = 3
) (
    input  logic [4*SIDE*SIDE-1:0][ACC_W-1:0] pscore,
    input  logic [3:0][ACC_W-1:0]             cscore,
    output logic [2*SIDE*SIDE-1:0]            corr,
    output logic [1:0]                        lcls
);
    localparam int Q = SIDE * SIDE;

    assign lcls = idx2pauli(argmax4(cscore));

    for (genvar q = 0; q < Q; q++) begin : g_qubit
        localparam bit ON_ROW = (q < SIDE);
        localparam bit ON_COL = ((q % SIDE) == 0);
        logic [1:0] guess;
        assign guess         = idx2pauli(argmax4(pscore[4*q +: 4]));
        assign corr[2*q + 1] = guess[1] ^ (ON_ROW & lcls[1]);
        assign corr[2*q]     = guess[0] ^ (ON_COL & lcls[0]);
    end
endmodule

// File: rtl/surface_nn_decoder.sv
module surface_nn_decoder
    import snd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [SYN_W-1:0] syndrome,
    input  logic            wr_en,
    input  logic            wr_net,
    input  logic            wr_layer,
    input  logic [AW-1:0]   wr_addr,
    input  logic [W_W-1:0]  wr_data,
    output logic            done,
    output logic [2*NQ-1:0] correction,
    output logic [1:0]      logical
);
    dec_state_t            state_q;
    logic                  busy, accept;
    logic [SYN_W-1:0]      syn_q;
    logic                  fin_p, fin_c;
    logic                  wr_p, wr_c;
    logic [P_OUT-1:0][ACC_W-1:0] pscore;
    logic [C_OUT-1:0][ACC_W-1:0] cscore;
    logic [2*NQ-1:0]       m_corr;
    logic [1:0]            m_log;

    assign busy   = (state_q == ST_RUN);
    assign accept = start && !busy;
    assign wr_p   = wr_en && !busy && !wr_net;
    assign wr_c   = wr_en && !busy &&  wr_net;

    snd_net_engine #(.IN_W(SYN_W), .HID_N(P_HID), .OUT_N(P_OUT)) u_pred (
        .clk(clk), .rst(rst), .go(accept), .syn(syn_q),
        .wr_en(wr_p), .wr_layer(wr_layer), .wr_addr(wr_addr), .wr_data(wr_data),
        .fin(fin_p), .score(pscore)
    );

    snd_net_engine #(.IN_W(SYN_W), .HID_N(C_HID), .OUT_N(C_OUT)) u_cls (
        .clk(clk), .rst(rst), .go(accept), .syn(syn_q),
        .wr_en(wr_c), .wr_layer(wr_layer), .wr_addr(wr_addr), .wr_data(wr_data),
        .fin(fin_c), .score(cscore)
    );

    snd_merge #(.SIDE(DIST)) u_merge (
        .pscore(pscore), .cscore(cscore), .corr(m_corr), .lcls(m_log)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            syn_q      <= '0;
            done       <= 1'b0;
            correction <= '0;
            logical    <= PAULI_I;
        end else begin
            done <= 1'b0;
            if (accept) begin
                syn_q   <= syndrome;
                state_q <= ST_RUN;
            end else if (busy && fin_p && fin_c) begin
                done       <= 1'b1;
                correction <= m_corr;
                logical    <= m_log;
                state_q    <= ST_IDLE;
            end
        end
    end

    // R7: done is a single-cycle pulse
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: both networks leave the finished state together when a start is taken
    a_r7_parallel_go: assert property (@(posedge clk) disable iff (rst)
        accept |=> (!fin_p && !fin_c));
    // R7: a result is only published after both networks are finished
    a_r7_after_both: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(fin_p && fin_c));
    // R7: outputs hold between done pulses
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(correction) && $stable(logical)));
    // R8: a start during a decode leaves the latched syndrome alone
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(syn_q));
endmodule

// File: tb/surface_nn_decoder_test.sv
module surface_nn_decoder_test;
    import snd_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 2 * C_HID + 1;
    localparam int P_R1       = SYN_W + 1;
    localparam int P_R2       = P_HID + 1;
    localparam int C_R2       = C_HID + 1;

    logic clk = 1'b0;
    logic rst, start, wr_en, wr_net, wr_layer, done;
    logic [SYN_W-1:0] syndrome;
    logic [AW-1:0] wr_addr;
    logic [W_W-1:0] wr_data;
    logic [2*NQ-1:0] correction;
    logic [1:0] logical;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit [31:0] seed = 32'h1234_5678;

    int pw1 [P_HID][P_R1];
    int pw2 [P_OUT][P_R2];
    int cw1 [C_HID][P_R1];
    int cw2 [C_OUT][C_R2];

    surface_nn_decoder uut (
        .clk(clk), .rst(rst), .start(start), .syndrome(syndrome),
        .wr_en(wr_en), .wr_net(wr_net), .wr_layer(wr_layer),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .done(done), .correction(correction), .logical(logical)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int clamp_h(input int v);
        if (v < 0) return 0;
        if (v > 127) return 127;
        return v;
    endfunction

    function automatic int clamp_a(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int best4(input int a0, input int a1, input int a2, input int a3);
        int b = 0; int bv = a0;
        if (a1 > bv) begin b = 1; bv = a1; end
        if (a2 > bv) begin b = 2; bv = a2; end
        if (a3 > bv) begin b = 3; end
        return b;
    endfunction

    function automatic logic [1:0] code_of(input int idx);
        case (idx)
            1: return 2'b10;
            2: return 2'b11;
            3: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // Integer model built from R2..R6
    task automatic model(input logic [SYN_W-1:0] s, output logic [2*NQ-1:0] c, output logic [1:0] l);
        int hp [P_HID];
        int hc [C_HID];
        int ps [P_OUT];
        int cs [C_OUT];
        for (int j = 0; j < P_HID; j++) begin
            int t = pw1[j][SYN_W];
            for (int i = 0; i < SYN_W; i++) if (s[i]) t += pw1[j][i];
            hp[j] = clamp_h(t);
        end
        for (int j = 0; j < C_HID; j++) begin
            int t = cw1[j][SYN_W];
            for (int i = 0; i < SYN_W; i++) if (s[i]) t += cw1[j][i];
            hc[j] = clamp_h(t);
        end
        for (int o = 0; o < P_OUT; o++) begin
            int a = pw2[o][P_HID];
            for (int j = 0; j < P_HID; j++) a = clamp_a(a + hp[j] * pw2[o][j]);
            ps[o] = a;
        end
        for (int o = 0; o < C_OUT; o++) begin
            int a = cw2[o][C_HID];
            for (int j = 0; j < C_HID; j++) a = clamp_a(a + hc[j] * cw2[o][j]);
            cs[o] = a;
        end
        l = code_of(best4(cs[0], cs[1], cs[2], cs[3]));
        for (int q = 0; q < NQ; q++) begin
            logic [1:0] g;
            g = code_of(best4(ps[4*q], ps[4*q+1], ps[4*q+2], ps[4*q+3]));
            if (q < DIST && l[1]) g[1] = ~g[1];
            if ((q % DIST) == 0 && l[0]) g[0] = ~g[0];
            c[2*q +: 2] = g;
        end
    endtask

    task automatic clear_model();
        for (int j = 0; j < P_HID; j++) for (int i = 0; i < P_R1; i++) pw1[j][i] = 0;
        for (int j = 0; j < C_HID; j++) for (int i = 0; i < P_R1; i++) cw1[j][i] = 0;
        for (int o = 0; o < P_OUT; o++) for (int j = 0; j < P_R2; j++) pw2[o][j] = 0;
        for (int o = 0; o < C_OUT; o++) for (int j = 0; j < C_R2; j++) cw2[o][j] = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
    endtask

    // Write one parameter; when shadow is set the bench model follows it
    task automatic wr(input bit net, input bit layer, input int addr, input int val, input bit shadow);
        @(negedge clk);
        wr_en = 1'b1; wr_net = net; wr_layer = layer;
        wr_addr = AW'(addr); wr_data = W_W'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (shadow) begin
            if (!net && !layer) pw1[addr / P_R1][addr % P_R1] = val;
            if (!net &&  layer) pw2[addr / P_R2][addr % P_R2] = val;
            if ( net && !layer) cw1[addr / P_R1][addr % P_R1] = val;
            if ( net &&  layer) cw2[addr / C_R2][addr % C_R2] = val;
        end
    endtask

    task automatic decode(input logic [SYN_W-1:0] s, output int lat);
        @(negedge clk);
        start = 1'b1; syndrome = s;
        @(posedge clk); #1;
        start = 1'b0;
        lat = 0;
        while (!done && lat < 1000) begin
            @(posedge clk); #1;
            lat++;
        end
    endtask

    task automatic decode_check(input logic [SYN_W-1:0] s, input string req);
        int lat;
        logic [2*NQ-1:0] ec;
        logic [1:0] el;
        model(s, ec, el);
        decode(s, lat);
        chk(correction == ec, req, 32'(correction), 32'(ec));
        chk(logical == el, req, 32'(logical), 32'(el));
    endtask

    task automatic t_reset();
        int lat;
        do_reset();
        #1;
        chk(done == 1'b0, "R1 done", 32'(done), 0);
        chk(correction == '0, "R1 correction", 32'(correction), 0);
        chk(logical == 2'b00, "R1 logical", 32'(logical), 0);
        // cleared weights give all-zero scores, ties pick I everywhere (R1, R4, R5)
        decode(8'hC3, lat);
        chk(correction == '0, "R1/R4 zero weights", 32'(correction), 0);
        chk(logical == 2'b00, "R1/R5 zero weights", 32'(logical), 0);
    endtask

    task automatic t_latency();
        int lat;
        do_reset();
        decode(8'h5A, lat);
        chk(lat == LAT, "R7 latency", 32'(lat), 32'(LAT));
        @(posedge clk); #1;
        chk(done == 1'b0, "R7 one-cycle done", 32'(done), 0);
        wr(1'b1, 1'b1, 1 * C_R2 + C_HID, 9, 1'b1);
        #1;
        chk(logical == 2'b00, "R7 outputs hold", 32'(logical), 0);
    endtask

    task automatic t_address();
        do_reset();
        wr(1'b0, 1'b0, 0 * P_R1 + 2, 50, 1'b1);
        wr(1'b0, 1'b1, 23 * P_R2 + 0, 1, 1'b1);
        decode_check(8'h04, "R2 addressed weight on");
        chk(correction == 18'h00400, "R2 qubit5 Z", 32'(correction), 32'h400);
        decode_check(8'hFB, "R2 addressed weight off");
        chk(correction == 18'h0, "R2 bit2 clear", 32'(correction), 0);
    endtask

    task automatic t_logical();
        int lat;
        do_reset();
        wr(1'b1, 1'b1, 1 * C_R2 + C_HID, 10, 1'b1);
        decode(8'h00, lat);
        chk(correction == 18'h0002A, "R6 logical X row", 32'(correction), 32'h2A);
        chk(logical == 2'b10, "R5 class X", 32'(logical), 2);
        wr(1'b1, 1'b1, 3 * C_R2 + C_HID, 20, 1'b1);
        decode(8'h00, lat);
        chk(correction == 18'h01041, "R6 logical Z column", 32'(correction), 32'h1041);
        chk(logical == 2'b01, "R5 class Z", 32'(logical), 1);
        wr(1'b1, 1'b1, 2 * C_R2 + C_HID, 30, 1'b1);
        decode(8'h00, lat);
        chk(correction == 18'h0106B, "R6 logical Y both", 32'(correction), 32'h106B);
        // predictor guesses: qubit0 Z, qubit4 X, then Y logical on top
        wr(1'b0, 1'b1, 3 * P_R2 + P_HID, 5, 1'b1);
        wr(1'b0, 1'b1, 17 * P_R2 + P_HID, 5, 1'b1);
        decode_check(8'h00, "R6 guess merged with Y");
        chk(correction == 18'h0126A, "R6 merge Y", 32'(correction), 32'h126A);
        wr(1'b1, 1'b1, 0 * C_R2 + C_HID, 40, 1'b1);
        decode(8'h00, lat);
        chk(correction == 18'h00201, "R6 class I passthrough", 32'(correction), 32'h201);
        chk(logical == 2'b00, "R5 class I", 32'(logical), 0);
    endtask

    task automatic t_tie();
        int lat;
        do_reset();
        wr(1'b1, 1'b1, 1 * C_R2 + C_HID, 7, 1'b1);
        wr(1'b1, 1'b1, 2 * C_R2 + C_HID, 7, 1'b1);
        wr(1'b0, 1'b1, 34 * P_R2 + P_HID, 3, 1'b1);
        wr(1'b0, 1'b1, 35 * P_R2 + P_HID, 3, 1'b1);
        decode(8'h11, lat);
        chk(logical == 2'b10, "R5 tie lower index", 32'(logical), 2);
        chk(correction == 18'h3002A, "R4 tie lower index", 32'(correction), 32'h3002A);
    endtask

    task automatic t_saturate();
        int lat;
        do_reset();
        for (int j = 0; j < C_HID; j++) begin
            wr(1'b1, 1'b0, j * P_R1 + SYN_W, 127, 1'b1);
            wr(1'b1, 1'b1, 1 * C_R2 + j, 127, 1'b1);
            wr(1'b1, 1'b1, 2 * C_R2 + j, 100, 1'b1);
            wr(1'b1, 1'b1, 3 * C_R2 + j, -128, 1'b1);
        end
        decode(8'h00, lat);
        chk(logical == 2'b10, "R3 saturation then tie", 32'(logical), 2);
        decode_check(8'hFF, "R3 saturation model");
    endtask

    task automatic t_random();
        logic [SYN_W-1:0] pats [10] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hA5,
                                        8'h5A, 8'h3C, 8'h18, 8'hE7, 8'h42};
        do_reset();
        for (int a = 0; a < P_HID * P_R1; a++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            wr(1'b0, 1'b0, a, int'($signed(seed[23:16])), 1'b1);
        end
        for (int a = 0; a < P_OUT * P_R2; a++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            wr(1'b0, 1'b1, a, int'($signed(seed[23:16])), 1'b1);
        end
        for (int a = 0; a < C_HID * P_R1; a++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            wr(1'b1, 1'b0, a, int'($signed(seed[23:16])), 1'b1);
        end
        for (int a = 0; a < C_OUT * C_R2; a++) begin
            seed = seed * 32'd1103515245 + 32'd12345;
            wr(1'b1, 1'b1, a, int'($signed(seed[23:16])) / 4, 1'b1);
        end
        for (int k = 0; k < 10; k++) decode_check(pats[k], "R2/R3/R4/R5/R6 random weights");
    endtask

    task automatic t_busy();
        int lat;
        int dones;
        logic [2*NQ-1:0] ec;
        logic [1:0] el;
        do_reset();
        wr(1'b1, 1'b1, 1 * C_R2 + C_HID, 10, 1'b1);
        wr(1'b1, 1'b0, 0 * P_R1 + 0, 100, 1'b1);
        wr(1'b1, 1'b1, 3 * C_R2 + 0, 1, 1'b1);
        model(8'h00, ec, el);
        // R8: second start mid-decode, R9: write mid-decode
        @(negedge clk);
        start = 1'b1; syndrome = 8'h00;
        @(negedge clk);
        start = 1'b0;
        dones = 0; lat = 1;
        repeat (5) @(negedge clk);
        start = 1'b1; syndrome = 8'h01;
        @(negedge clk);
        start = 1'b0;
        wr(1'b1, 1'b1, 3 * C_R2 + C_HID, 60, 1'b0);
        repeat (2 * LAT) begin
            @(posedge clk); #1;
            if (done) dones++;
        end
        chk(dones == 1, "R8 single done", 32'(dones), 1);
        chk(correction == ec, "R8 first syndrome result", 32'(correction), 32'(ec));
        decode(8'h00, lat);
        chk(logical == 2'b10, "R9 busy write dropped", 32'(logical), 2);
        decode_check(8'h01, "R8/R9 follow-up decode");
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; wr_en = 1'b0; wr_net = 1'b0; wr_layer = 1'b0;
        wr_addr = '0; wr_data = '0; syndrome = '0;
        t_reset();
        t_latency();
        t_address();
        t_logical();
        t_tie();
        t_saturate();
        t_random();
        t_busy();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule